// File: doc/BRIEF.md
# Guarded Code Read-Out with Key Scrambling

This block is the programming and read-back path of an on-chip program store. It holds a byte array for code, a 64-byte scrambling key table, three lock fuses and three fixed identity bytes. When software or a programmer reads code back in verify mode, the block does not return the stored byte as is. It returns the stored byte XNOR a key byte, and the key byte is picked by the low six address bits. Once the fuses reach a high enough grade, the read returns nothing useful.

Writes behave like a one-time-programmable cell. A write can only clear bits. A write commits only after a fixed number of program pulses have been seen on the same target. That number is 5 for a code byte and 25 for a key byte or a fuse. The fuses cannot be read. Their grade shows only through the features they turn off:
- code and key programming;
- verify reads;
- external-access sampling;
- table reads from external code;
- external execution.

An erase input returns every store to all ones.

Top module: `secure_verify`

## Requirements
- R1: Holding `erase_i` high for a cycle sets every code byte, every key byte and every fuse to the erased (all ones) state. After that, verify reads return 0xFF, both block outputs read 0, and `ext_access_o` follows `ea_pin_i`.
- R2: With `mode_i`=2 (verify), `rdata_o` one clock later equals NOT(code[addr] XOR key[addr[5:0]]) while the fuse grade is below two.
- R3: With an erased key table, a verify read returns the stored code byte unchanged, and key index aliasing repeats every 64 addresses.
- R4: With `mode_i`=1 (program code), the 5th pulse on an unchanged mode and address commits code[addr] = old AND `wdata_i`. `prog_done_o` is high for exactly the one cycle after that pulse. Fewer pulses, or a change of address between pulses, commit nothing and restart the count. Mode 0 is idle.
- R5: Modes 3 (program key byte addr[5:0]) and 4, 5, 6 (program fuse 1, 2, 3) commit on the 25th pulse, and never on an earlier one.
- R6: While fuse 1 is programmed, pulses in modes 1 and 3 are ignored: no commit and no `prog_done_o`.
- R7: With fuses 1 and 2 programmed, verify reads return 0xFF.
- R8: With `mode_i`=7, reads return 0x89 at address 0x30, 0x58 at 0x31, the variant byte (default 0xFC) at 0x60, and 0xFF elsewhere, whatever the fuse grade.
- R9: With fuse 1 programmed, `ext_access_o` holds the value `ea_pin_i` had during the last reset. Otherwise it follows `ea_pin_i`.
- R10: The fuse grade counts programmed fuses only as an unbroken run starting at fuse 1. Grade 1 or more raises `ext_table_block_o`. Only grade 3 raises `ext_exec_block_o`. Fuse 2 or 3 alone leaves every feature enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also samples the external-access pin |
| erase_i | input | 1 | Erase all stores to ones |
| mode_i | input | 3 | Operation select (0 idle .. 7 identity read) |
| addr_i | input | 14 | Target address |
| wdata_i | input | 8 | Byte to program |
| pulse_i | input | 1 | Program pulse, one count per high cycle |
| ea_pin_i | input | 1 | External-access strap |
| rdata_o | output | 8 | Registered read data |
| prog_done_o | output | 1 | One-cycle commit indication |
| ext_access_o | output | 1 | Effective external-access level |
| ext_table_block_o | output | 1 | Table reads from external code blocked |
| ext_exec_block_o | output | 1 | External execution blocked |

## Verification
Verify reads sweep 128 addresses with a distinct code pattern and a distinct key pattern. This separates a wrong key index, since the upper 64 addresses reuse the same keys over unprogrammed code. It also catches a missing inversion and plain pass-through. Pulse trains are counted one pulse at a time, so an early or late commit shows at the exact pulse. Interrupted trains check that the count restarts when the address changes. Fuses are programmed one at a time in rising order and then out of order after an erase, which tells the grade decode apart from a plain per-fuse decode.

// File: rtl/secure_verify_pkg.sv
package secure_verify_pkg;

    localparam int SV_ADDR_W  = 14;
    localparam int SV_DATA_W  = 8;
    localparam int SV_KEY_AW  = 6;

    typedef enum logic [2:0] {
        MODE_IDLE      = 3'd0,
        MODE_PROG_CODE = 3'd1,
        MODE_VERIFY    = 3'd2,
        MODE_PROG_KEY  = 3'd3,
        MODE_PROG_F1   = 3'd4,
        MODE_PROG_F2   = 3'd5,
        MODE_PROG_F3   = 3'd6,
        MODE_IDENT     = 3'd7
    } sv_mode_e;

    typedef enum logic [1:0] {
        GRADE_OPEN   = 2'd0,
        GRADE_SEALED = 2'd1,
        GRADE_NOREAD = 2'd2,
        GRADE_NOEXT  = 2'd3
    } sv_grade_e;

    typedef enum logic [1:0] {
        WR_CODE = 2'd0,
        WR_KEY  = 2'd1,
        WR_FUSE = 2'd2
    } sv_wr_kind_e;

    typedef struct packed {
        logic                   en;
        sv_wr_kind_e            kind;
        logic [SV_ADDR_W-1:0]   addr;
        logic [SV_DATA_W-1:0]   data;
        logic [1:0]             fuse;
    } sv_wr_req_t;

    typedef struct packed {
        logic                   valid;
        sv_mode_e               mode;
        logic [SV_ADDR_W-1:0]   addr;
    } sv_target_t;

    localparam logic [SV_ADDR_W-1:0] ID_ADDR0 = 14'h0030;
    localparam logic [SV_ADDR_W-1:0] ID_ADDR1 = 14'h0031;
    localparam logic [SV_ADDR_W-1:0] ID_ADDR2 = 14'h0060;
    localparam logic [SV_DATA_W-1:0] ID_BYTE0 = 8'h89;
    localparam logic [SV_DATA_W-1:0] ID_BYTE1 = 8'h58;

    // fuse bit = 1 means unprogrammed; grade counts the unbroken run from fuse 1
    function automatic sv_grade_e grade_of(input logic [2:0] fuses);
        if (fuses[0]) return GRADE_OPEN;
        if (fuses[1]) return GRADE_SEALED;
        if (fuses[2]) return GRADE_NOREAD;
        return GRADE_NOEXT;
    endfunction

    function automatic logic is_prog_mode(input sv_mode_e m);
        return (m == MODE_PROG_CODE) || (m == MODE_PROG_KEY) ||
               (m == MODE_PROG_F1)   || (m == MODE_PROG_F2)  ||
               (m == MODE_PROG_F3);
    endfunction

    function automatic logic is_sealable(input sv_mode_e m);
        return (m == MODE_PROG_CODE) || (m == MODE_PROG_KEY);
    endfunction

endpackage

// File: rtl/sv_pulse_ctr.sv
module sv_pulse_ctr
    import secure_verify_pkg::*;
#(
    parameter int CODE_PULSES = 5,
    parameter int AUX_PULSES  = 25
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  erase,
    input  sv_mode_e              mode,
    input  logic [SV_ADDR_W-1:0]  addr,
    input  logic [SV_DATA_W-1:0]  wdata,
    input  logic                  pulse,
    input  sv_grade_e             grade,
    output sv_wr_req_t            wr,
    output logic                  done
);
    localparam int MAXP = (CODE_PULSES > AUX_PULSES) ? CODE_PULSES : AUX_PULSES;
    localparam int CW   = $clog2(MAXP + 1);
    localparam logic [CW-1:0] NEED_CODE = CW'(CODE_PULSES - 1);
    localparam logic [CW-1:0] NEED_AUX  = CW'(AUX_PULSES - 1);

    sv_target_t     tgt_q;
    logic [CW-1:0]  cnt_q, eff, last_idx;
    logic           same, pulse_ok, fire, done_q;

    always_comb begin
        same     = tgt_q.valid && (tgt_q.mode == mode) && (tgt_q.addr == addr);
        eff      = same ? cnt_q : '0;
        last_idx = (mode == MODE_PROG_CODE) ? NEED_CODE : NEED_AUX;
        pulse_ok = pulse && is_prog_mode(mode) &&
                   !(is_sealable(mode) && (grade != GRADE_OPEN));
        fire     = pulse_ok && (eff == last_idx);
    end

    always_comb begin
        wr.en   = fire;
        wr.addr = addr;
        wr.data = wdata;
        wr.fuse = 2'(mode - MODE_PROG_F1);
        unique case (mode)
            MODE_PROG_CODE: wr.kind = WR_CODE;
            MODE_PROG_KEY:  wr.kind = WR_KEY;
            default:        wr.kind = WR_FUSE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || erase) begin
            tgt_q  <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            tgt_q.valid <= 1'b1;
            tgt_q.mode  <= mode;
            tgt_q.addr  <= addr;
            done_q      <= fire;
            if (fire)          cnt_q <= '0;
            else if (pulse_ok) cnt_q <= eff + 1'b1;
            else               cnt_q <= eff;
        end
    end

    assign done = done_q;

    // R4: commit indication lasts a single cycle
    assert_done_single_R4: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R5: running count never reaches the largest pulse requirement
    assert_count_bound_R5: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CW'(MAXP));

    // R4: a committed write is always followed by the done pulse
    assert_fire_done_R4: assert property (@(posedge clk) disable iff (rst)
        (fire && !erase) |=> done_q);

endmodule

// File: rtl/sv_store.sv
module sv_store
    import secure_verify_pkg::*;
#(
    parameter int MEM_AW = 10
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  erase,
    input  sv_wr_req_t            wr,
    input  logic [SV_ADDR_W-1:0]  raddr,
    output logic [SV_DATA_W-1:0]  code_byte,
    output logic [SV_DATA_W-1:0]  key_byte,
    output sv_grade_e             grade
);
    localparam int DEPTH     = 1 << MEM_AW;
    localparam int KEY_DEPTH = 1 << SV_KEY_AW;

    logic [SV_DATA_W-1:0] code_q [DEPTH];
    logic [SV_DATA_W-1:0] key_q  [KEY_DEPTH];
    logic [2:0]           fuse_q;

    logic [MEM_AW-1:0]    wr_ci, rd_ci;
    logic [SV_KEY_AW-1:0] wr_ki, rd_ki;

    assign wr_ci = wr.addr[MEM_AW-1:0];
    assign wr_ki = wr.addr[SV_KEY_AW-1:0];
    assign rd_ci = raddr[MEM_AW-1:0];
    assign rd_ki = raddr[SV_KEY_AW-1:0];

    always_ff @(posedge clk) begin
        if (erase) begin
            for (int i = 0; i < DEPTH; i++)     code_q[i] <= '1;
            for (int j = 0; j < KEY_DEPTH; j++) key_q[j]  <= '1;
            fuse_q <= 3'b111;
        end else if (wr.en) begin
            unique case (wr.kind)
                WR_CODE: code_q[wr_ci] <= code_q[wr_ci] & wr.data;
                WR_KEY:  key_q[wr_ki]  <= key_q[wr_ki] & wr.data;
                default: fuse_q[wr.fuse] <= 1'b0;
            endcase
        end
    end

    assign code_byte = code_q[rd_ci];
    assign key_byte  = key_q[rd_ki];
    assign grade     = grade_of(fuse_q);

    // R1: a fuse returns to unprogrammed only through erase
    assert_fuse_sticky_R1: assert property (@(posedge clk) disable iff (rst)
        !$past(erase) |-> ((fuse_q & ~$past(fuse_q)) == 3'b000));

    // R6: code and key stores are not written once sealed
    assert_sealed_nowrite_R6: assert property (@(posedge clk) disable iff (rst)
        (wr.en && (wr.kind != WR_FUSE)) |-> (grade == GRADE_OPEN));

endmodule

// File: rtl/sv_readout.sv
module sv_readout
    import secure_verify_pkg::*;
#(
    parameter logic [SV_DATA_W-1:0] ID_VARIANT = 8'hFC
) (
    input  logic                  clk,
    input  logic                  rst,
    input  sv_mode_e              mode,
    input  logic [SV_ADDR_W-1:0]  addr,
    input  logic [SV_DATA_W-1:0]  code_byte,
    input  logic [SV_DATA_W-1:0]  key_byte,
    input  sv_grade_e             grade,
    output logic [SV_DATA_W-1:0]  rdata
);
    logic [SV_DATA_W-1:0] rd_d, rd_q, ident;

    always_comb begin
        unique case (addr)
            ID_ADDR0: ident = ID_BYTE0;
            ID_ADDR1: ident = ID_BYTE1;
            ID_ADDR2: ident = ID_VARIANT;
            default:  ident = '1;
        endcase
    end

    always_comb begin
        rd_d = '1;
        if (mode == MODE_VERIFY) begin
            if (grade < GRADE_NOREAD) rd_d = ~(code_byte ^ key_byte);
        end else if (mode == MODE_IDENT) begin
            rd_d = ident;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rd_q <= '1;
        else     rd_q <= rd_d;
    end

    assign rdata = rd_q;

    // R7: verify is blanked at grade two and above
    assert_verify_blank_R7: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_VERIFY && grade >= GRADE_NOREAD) |=> (rd_q == 8'hFF));

    // R8: first identity byte
    assert_ident0_R8: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_IDENT && addr == ID_ADDR0) |=> (rd_q == ID_BYTE0));

    // R2: scrambled verify reads back through the inverse operation
    assert_verify_xnor_R2: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_VERIFY && grade < GRADE_NOREAD) |=>
            ((rd_q ^ $past(key_byte)) == ~$past(code_byte)));

endmodule

// File: rtl/secure_verify.sv
module secure_verify
    import secure_verify_pkg::*;
#(
    parameter int                   MEM_AW      = 10,
    parameter int                   CODE_PULSES = 5,
    parameter int                   AUX_PULSES  = 25,
    parameter logic [7:0]           ID_VARIANT  = 8'hFC
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        erase_i,
    input  logic [2:0]  mode_i,
    input  logic [13:0] addr_i,
    input  logic [7:0]  wdata_i,
    input  logic        pulse_i,
    input  logic        ea_pin_i,
    output logic [7:0]  rdata_o,
    output logic        prog_done_o,
    output logic        ext_access_o,
    output logic        ext_table_block_o,
    output logic        ext_exec_block_o
);
    sv_mode_e             mode;
    sv_grade_e            grade;
    sv_wr_req_t           wr;
    logic [SV_DATA_W-1:0] code_byte, key_byte;
    logic                 ea_q;

    assign mode = sv_mode_e'(mode_i);

    sv_pulse_ctr #(
        .CODE_PULSES (CODE_PULSES),
        .AUX_PULSES  (AUX_PULSES)
    ) u_ctr (
        .clk   (clk),
        .rst   (rst),
        .erase (erase_i),
        .mode  (mode),
        .addr  (addr_i),
        .wdata (wdata_i),
        .pulse (pulse_i),
        .grade (grade),
        .wr    (wr),
        .done  (prog_done_o)
    );

    sv_store #(
        .MEM_AW (MEM_AW)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .erase     (erase_i),
        .wr        (wr),
        .raddr     (addr_i),
        .code_byte (code_byte),
        .key_byte  (key_byte),
        .grade     (grade)
    );

    sv_readout #(
        .ID_VARIANT (ID_VARIANT)
    ) u_rd (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .addr      (addr_i),
        .code_byte (code_byte),
        .key_byte  (key_byte),
        .grade     (grade),
        .rdata     (rdata_o)
    );

    always_ff @(posedge clk) begin
        if (rst) ea_q <= ea_pin_i;
    end

    assign ext_access_o      = (grade == GRADE_OPEN) ? ea_pin_i : ea_q;
    assign ext_table_block_o = (grade != GRADE_OPEN);
    assign ext_exec_block_o  = (grade == GRADE_NOEXT);

    // R9: once sealed the effective access level ignores the pin
    assert_ea_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (grade != GRADE_OPEN && !erase_i) |=> $stable(ext_access_o));

    // R10: execution block implies table block
    assert_block_order_R10: assert property (@(posedge clk) disable iff (rst)
        ext_exec_block_o |-> ext_table_block_o);

endmodule

// File: tb/secure_verify_bench.sv
`timescale 1ns/1ps
module secure_verify_bench;
    localparam logic [2:0] M_IDLE = 3'd0, M_CODE = 3'd1, M_VER = 3'd2, M_KEY = 3'd3,
                           M_F1 = 3'd4, M_F2 = 3'd5, M_F3 = 3'd6, M_ID = 3'd7;

    logic        clk = 1'b0;
    logic        rst, erase_i, pulse_i, ea_pin_i;
    logic [2:0]  mode_i;
    logic [13:0] addr_i;
    logic [7:0]  wdata_i;
    logic [7:0]  rdata_o;
    logic        prog_done_o, ext_access_o, ext_table_block_o, ext_exec_block_o;

    int total = 0;
    int bad   = 0;
    logic [7:0] code_m [1024];
    logic [7:0] key_m  [64];

    always #5 clk = ~clk;

    secure_verify u_secure_verify (
        .clk(clk), .rst(rst), .erase_i(erase_i), .mode_i(mode_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .pulse_i(pulse_i), .ea_pin_i(ea_pin_i), .rdata_o(rdata_o),
        .prog_done_o(prog_done_o), .ext_access_o(ext_access_o),
        .ext_table_block_o(ext_table_block_o), .ext_exec_block_o(ext_exec_block_o)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic target(logic [2:0] m, logic [13:0] a, logic [7:0] d);
        mode_i = m; addr_i = a; wdata_i = d;
    endtask

    task automatic pulses(int n, bit commit, string req);
        for (int i = 1; i <= n; i++) begin
            pulse_i = 1'b1;
            @(negedge clk);
            pulse_i = 1'b0;
            chk(req, {7'd0, prog_done_o}, {7'd0, commit && (i == n)});
            @(negedge clk);
        end
    endtask

    task automatic rd(logic [2:0] m, logic [13:0] a, output logic [7:0] v);
        target(m, a, 8'h00);
        @(negedge clk);
        v = rdata_o;
    endtask

    function automatic logic [7:0] exp_ver(int a);
        return ~(code_m[a % 1024] ^ key_m[a % 64]);
    endfunction

    task automatic blocks(string req, bit tb, bit eb);
        chk(req, {6'd0, ext_table_block_o, ext_exec_block_o}, {6'd0, tb, eb});
    endtask

    initial begin
        #2_000_000;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        rst = 1'b1; erase_i = 1'b1; pulse_i = 1'b0; ea_pin_i = 1'b1;
        target(M_IDLE, 14'd0, 8'd0);
        for (int i = 0; i < 1024; i++) code_m[i] = 8'hFF;
        for (int i = 0; i < 64; i++)   key_m[i]  = 8'hFF;
        repeat (3) @(negedge clk);
        chk("R1 reset rdata", rdata_o, 8'hFF);
        chk("R4 reset done", {7'd0, prog_done_o}, 8'd0);
        rst = 1'b0; erase_i = 1'b0;
        @(negedge clk);
        blocks("R1 erased blocks", 1'b0, 1'b0);
        ea_pin_i = 1'b0; #1;
        chk("R9 open follows pin", {7'd0, ext_access_o}, 8'd0);
        ea_pin_i = 1'b1; #1;
        chk("R9 open follows pin", {7'd0, ext_access_o}, 8'd1);

        for (int a = 0; a < 64; a++) begin
            rd(M_VER, 14'(a), v);
            chk("R1 erased verify", v, 8'hFF);
        end

        // R4: program code bytes, five pulses each
        for (int a = 0; a < 64; a++) begin
            target(M_CODE, 14'(a), 8'((a * 37 + 5) & 255));
            pulses(5, 1'b1, "R4 code commit");
            code_m[a] = code_m[a] & 8'((a * 37 + 5) & 255);
        end
        for (int a = 0; a < 128; a++) begin
            rd(M_VER, 14'(a), v);
            chk("R3 plain verify", v, exp_ver(a));
        end

        // R4: interrupted train restarts the count
        target(M_CODE, 14'd100, 8'h3A); pulses(3, 1'b0, "R4 partial");
        target(M_CODE, 14'd101, 8'h3A); pulses(2, 1'b0, "R4 partial other addr");
        target(M_CODE, 14'd100, 8'h3A); pulses(2, 1'b0, "R4 restart no commit");
        rd(M_VER, 14'd100, v);
        chk("R4 no early write", v, exp_ver(100));
        target(M_CODE, 14'd100, 8'h3A); pulses(5, 1'b1, "R4 restart commit");
        code_m[100] = 8'h3A;
        rd(M_VER, 14'd100, v);
        chk("R4 restart value", v, exp_ver(100));

        // R4: bits only clear
        target(M_CODE, 14'd0, 8'h5C); pulses(5, 1'b1, "R4 and commit");
        code_m[0] = code_m[0] & 8'h5C;
        rd(M_VER, 14'd0, v);
        chk("R4 and result", v, exp_ver(0));

        // R5: key bytes, 25 pulses each
        for (int i = 0; i < 64; i++) begin
            target(M_KEY, 14'(i), 8'(((i * 11) ^ 8'h5A) & 255));
            pulses(25, 1'b1, "R5 key commit");
            key_m[i] = key_m[i] & 8'(((i * 11) ^ 8'h5A) & 255);
        end
        for (int a = 0; a < 128; a++) begin
            rd(M_VER, 14'(a), v);
            chk("R2 scrambled verify", v, exp_ver(a));
        end

        rd(M_ID, 14'h030, v); chk("R8 id 30", v, 8'h89);
        rd(M_ID, 14'h031, v); chk("R8 id 31", v, 8'h58);
        rd(M_ID, 14'h060, v); chk("R8 id 60", v, 8'hFC);
        rd(M_ID, 14'h061, v); chk("R8 id other", v, 8'hFF);

        // R5/R10: fuse 1
        target(M_F1, 14'd0, 8'd0); pulses(25, 1'b1, "R5 fuse1 commit");
        blocks("R10 grade1", 1'b1, 1'b0);
        rd(M_VER, 14'd5, v); chk("R2 grade1 verify", v, exp_ver(5));

        // R6: sealed programming ignored
        target(M_CODE, 14'd5, 8'h00); pulses(5, 1'b0, "R6 code ignored");
        target(M_KEY, 14'd5, 8'h00);  pulses(25, 1'b0, "R6 key ignored");
        rd(M_VER, 14'd5, v); chk("R6 unchanged", v, exp_ver(5));

        // R9: latch at reset
        ea_pin_i = 1'b0; rst = 1'b1;
        @(negedge clk); @(negedge clk);
        rst = 1'b0; ea_pin_i = 1'b1; #1;
        chk("R9 latched", {7'd0, ext_access_o}, 8'd0);
        @(negedge clk);
        chk("R9 latched later", {7'd0, ext_access_o}, 8'd0);

        // R7: fuse 2
        target(M_F2, 14'd0, 8'd0); pulses(25, 1'b1, "R5 fuse2 commit");
        blocks("R10 grade2", 1'b1, 1'b0);
        for (int a = 0; a < 8; a++) begin
            rd(M_VER, 14'(a), v); chk("R7 blank verify", v, 8'hFF);
        end
        rd(M_ID, 14'h031, v); chk("R8 id when blanked", v, 8'h58);

        target(M_F3, 14'd0, 8'd0); pulses(25, 1'b1, "R5 fuse3 commit");
        blocks("R10 grade3", 1'b1, 1'b1);

        // R1: erase
        erase_i = 1'b1; @(negedge clk); erase_i = 1'b0;
        for (int i = 0; i < 1024; i++) code_m[i] = 8'hFF;
        for (int i = 0; i < 64; i++)   key_m[i]  = 8'hFF;
        blocks("R1 erase blocks", 1'b0, 1'b0);
        ea_pin_i = 1'b0; #1;
        chk("R1 erase pin follow", {7'd0, ext_access_o}, 8'd0);
        for (int a = 0; a < 64; a++) begin
            rd(M_VER, 14'(a), v); chk("R1 erase verify", v, 8'hFF);
        end

        // R10: out-of-order fuses leave features on
        target(M_F2, 14'd0, 8'd0); pulses(25, 1'b1, "R10 fuse2 alone");
        target(M_F3, 14'd0, 8'd0); pulses(25, 1'b1, "R10 fuse3 alone");
        blocks("R10 no grade", 1'b0, 1'b0);
        target(M_CODE, 14'd7, 8'h3C); pulses(5, 1'b1, "R10 code still open");
        code_m[7] = 8'h3C;
        rd(M_VER, 14'd7, v); chk("R10 verify open", v, exp_ver(7));
        target(M_F1, 14'd0, 8'd0); pulses(25, 1'b1, "R10 fuse1 last");
        blocks("R10 full grade", 1'b1, 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule